// File: doc/BRIEF.md
# Dual-Direction Interprocessor Mailbox

This block lets two processors, called side A and side B, hand short messages to each other. Each direction has its own register bank with several channels. A channel holds a 32-bit command word and a 32-bit data word. The sender writes the command word first and then the data word. Writing the data word raises the channel's pending bit, and when the receiver has enabled that channel, a dedicated interrupt line toward the receiver goes high. The receiver reads the words and then clears the pending bit by writing a one to its position in the status register.

Each side reaches the whole register map through its own zero-wait-state APB-style port. A write is taken in the cycle where select, enable and write are all high. Read data is combinational from the address. Both ports read every register, but write ownership is split:

- The sender of a bank owns its command and data words.
- The receiver of a bank owns its enable and status registers.
- Writes from the port that does not own a register are dropped.

The reset input is asynchronous and active low. Internally it is released synchronously, two clock edges after `rst_n` rises.

Top module: `mbox_top`

## Requirements
- R1: Reset clears every enable bit, pending bit, command word and data word, and drives both interrupt vectors to zero.
- R2: Command words sit at 0x08+8n and data words at 0x0C+8n in the A-to-B bank (n = channel 0..3). Both are 32 bits wide, and both ports read back the last value written.
- R3: A sender write to channel n's data word sets bit n of that bank's status register (A-to-B status at 0x04, B-to-A status at 0x2C).
- R4: A receiver write to a status register clears each pending bit whose written bit is one. Written zeros leave the pending bits unchanged.
- R5: Bit n of an enable register (A-to-B at 0x00, B-to-A at 0x28) enables channel n. Interrupt bit n is the registered AND of pending bit n and enable bit n, so it changes one clock after either input changes. Writing 0xF enables all four channels and writing 0 disables them.
- R6: An asserted interrupt line stays high until its pending bit is cleared, or until its enable bit is removed.
- R7: The B-to-A bank mirrors the A-to-B layout at base 0x28. Its command words are at 0x30+8n and its data words at 0x34+8n. It drives `irq_to_a`.
- R8: Reads of unmapped addresses return zero, and writes to them have no effect. Unmapped addresses are 0x50 and above, plus any address that is not word-aligned.
- R9: Write ownership is split as follows, and writes from the other port are ignored:
  - Port A owns the A-to-B command and data words, and the B-to-A enable and status registers.
  - Port B owns the B-to-A command and data words, and the A-to-B enable and status registers.
- R10: If a data write and a status clear reach the same channel in the same cycle, the channel's pending bit ends up set.
- R11: A command-word write alone does not change the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 1 | Side A select |
| a_enable | input | 1 | Side A access phase |
| a_write | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 8 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data |
| b_sel | input | 1 | Side B select |
| b_enable | input | 1 | Side B access phase |
| b_write | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 8 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data |
| irq_to_b | output | 4 | Per-channel interrupts from the A-to-B bank |
| irq_to_a | output | 4 | Per-channel interrupts from the B-to-A bank |

## Verification
Two functions can land on the same channel in the same cycle: the sender setting the pending bit through a data write, and the receiver clearing it through a status write. Because each comes from a different port, the bench drives both ports in the same access cycle. Port A writes channel 0's data word while port B writes a one to bit 0 of the A-to-B status register. The outcome is judged at the ports. Status bit 0 must read as one afterwards, and `irq_to_b` bit 0 must rise one clock after the channel is enabled.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_EN,
    RK_ST,
    RK_CMD,
    RK_DAT
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e kind;
    int        chan;
  } reg_dec_t;

  // Decode a byte offset inside one direction's bank.
  function automatic reg_dec_t decode_ofs(input int ofs, input int nch);
    reg_dec_t d;
    d.kind = RK_NONE;
    d.chan = 0;
    if (ofs == 0) begin
      d.kind = RK_EN;
    end else if (ofs == 4) begin
      d.kind = RK_ST;
    end else if (ofs >= 8 && ofs < 8 + 8 * nch && (ofs % 4) == 0) begin
      d.chan = (ofs - 8) / 8;
      d.kind = (((ofs - 8) % 8) == 4) ? RK_DAT : RK_CMD;
    end
    return d;
  endfunction

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snd_we,
  input  logic [AW-1:0]           snd_ofs,
  input  logic [DW-1:0]           snd_wdata,
  input  logic                    rcv_we,
  input  logic [AW-1:0]           rcv_ofs,
  input  logic [DW-1:0]           rcv_wdata,
  output logic [NCH-1:0][DW-1:0]  cmd_o,
  output logic [NCH-1:0][DW-1:0]  dat_o,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          pend_o,
  output logic [NCH-1:0]          irq_o
);

  reg_dec_t snd_dec;
  reg_dec_t rcv_dec;

  logic [NCH-1:0] cmd_we;
  logic [NCH-1:0] dat_we;
  logic [NCH-1:0] clr_mask;
  logic           en_we;

  logic [NCH-1:0][DW-1:0] cmd_q;
  logic [NCH-1:0][DW-1:0] dat_q;
  logic [NCH-1:0]         en_q;
  logic [NCH-1:0]         en_nxt;
  logic [NCH-1:0]         pend_q;
  logic [NCH-1:0]         pend_nxt;
  logic [NCH-1:0]         irq_q;
  logic [NCH-1:0]         irq_nxt;

  wire unused_rcv_hi = &{1'b0, rcv_wdata[DW-1:NCH]};

  // Write strobes
  always_comb begin
    snd_dec = decode_ofs(int'(snd_ofs), NCH);
    rcv_dec = decode_ofs(int'(rcv_ofs), NCH);
    for (int n = 0; n < NCH; n++) begin
      cmd_we[n] = snd_we && (snd_dec.kind == RK_CMD) && (snd_dec.chan == n);
      dat_we[n] = snd_we && (snd_dec.kind == RK_DAT) && (snd_dec.chan == n);
    end
    en_we    = rcv_we && (rcv_dec.kind == RK_EN);
    clr_mask = (rcv_we && (rcv_dec.kind == RK_ST)) ? rcv_wdata[NCH-1:0] : '0;
  end

  // Next state: set beats clear
  always_comb begin
    en_nxt   = en_we ? rcv_wdata[NCH-1:0] : en_q;
    pend_nxt = (pend_q & ~clr_mask) | dat_we;
    irq_nxt  = pend_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      en_q   <= en_nxt;
      pend_q <= pend_nxt;
      irq_q  <= irq_nxt;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q[n] <= '0;
        dat_q[n] <= '0;
      end else begin
        if (cmd_we[n]) cmd_q[n] <= snd_wdata;
        if (dat_we[n]) dat_q[n] <= snd_wdata;
      end
    end

    assert_data_sets_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dat_we[n] |=> pend_q[n]);
    assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[n] && !dat_we[n]) |=> !pend_q[n]);
    assert_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_mask[n] && pend_q[n]) |=> pend_q[n]);
    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_we[n] |=> $stable(cmd_q[n]));
    assert_cmd_no_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we[n] && !pend_q[n]) |=> !pend_q[n]);
    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q[n]) |-> $past(pend_q[n] && en_q[n]));
    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[n] && en_q[n]) |=> irq_q[n]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we[n] && clr_mask[n]) |=> pend_q[n]);
  end

  assign cmd_o  = cmd_q;
  assign dat_o  = dat_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
  import mbox_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic [AW-1:0]          addr,
  input  logic [NCH-1:0][DW-1:0] cmd0,
  input  logic [NCH-1:0][DW-1:0] dat0,
  input  logic [NCH-1:0]         en0,
  input  logic [NCH-1:0]         pend0,
  input  logic [NCH-1:0][DW-1:0] cmd1,
  input  logic [NCH-1:0][DW-1:0] dat1,
  input  logic [NCH-1:0]         en1,
  input  logic [NCH-1:0]         pend1,
  output logic [DW-1:0]          rdata
);

  localparam int            SPAN   = 8 + 8 * NCH;
  localparam logic [AW-1:0] SPAN_A = AW'(SPAN);
  localparam logic [AW-1:0] END_A  = AW'(2 * SPAN);

  reg_dec_t d;
  logic     sel1;
  logic     hit;

  always_comb begin
    sel1  = (addr >= SPAN_A);
    hit   = (addr < END_A);
    d     = decode_ofs(int'(sel1 ? addr - SPAN_A : addr), NCH);
    rdata = '0;
    if (hit) begin
      case (d.kind)
        RK_EN:  rdata = {{(DW-NCH){1'b0}}, (sel1 ? en1 : en0)};
        RK_ST:  rdata = {{(DW-NCH){1'b0}}, (sel1 ? pend1 : pend0)};
        RK_CMD: for (int n = 0; n < NCH; n++)
                  if (d.chan == n) rdata = sel1 ? cmd1[n] : cmd0[n];
        RK_DAT: for (int n = 0; n < NCH; n++)
                  if (d.chan == n) rdata = sel1 ? dat1[n] : dat0[n];
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/mbox_top.sv
module mbox_top #(
  parameter int NCH = 4,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           a_sel,
  input  logic           a_enable,
  input  logic           a_write,
  input  logic [AW-1:0]  a_addr,
  input  logic [DW-1:0]  a_wdata,
  output logic [DW-1:0]  a_rdata,
  input  logic           b_sel,
  input  logic           b_enable,
  input  logic           b_write,
  input  logic [AW-1:0]  b_addr,
  input  logic [DW-1:0]  b_wdata,
  output logic [DW-1:0]  b_rdata,
  output logic [NCH-1:0] irq_to_b,
  output logic [NCH-1:0] irq_to_a
);

  localparam int            SPAN   = 8 + 8 * NCH;
  localparam logic [AW-1:0] SPAN_A = AW'(SPAN);
  localparam logic [AW-1:0] END_A  = AW'(2 * SPAN);

  logic rst_sync_n;

  logic a_acc, b_acc;
  logic a_in0, a_in1, b_in0, b_in1;
  logic [AW-1:0] a_ofs1, b_ofs1;

  logic [NCH-1:0][DW-1:0] cmd_ab, dat_ab, cmd_ba, dat_ba;
  logic [NCH-1:0]         en_ab, pend_ab, en_ba, pend_ba;

  mbox_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    a_acc  = a_sel & a_enable & a_write;
    b_acc  = b_sel & b_enable & b_write;
    a_in0  = (a_addr < SPAN_A);
    b_in0  = (b_addr < SPAN_A);
    a_in1  = (a_addr >= SPAN_A) && (a_addr < END_A);
    b_in1  = (b_addr >= SPAN_A) && (b_addr < END_A);
    a_ofs1 = a_addr - SPAN_A;
    b_ofs1 = b_addr - SPAN_A;
  end

  // A-to-B: A sends, B receives
  mbox_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_bank_ab (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .snd_we    (a_acc & a_in0),
    .snd_ofs   (a_addr),
    .snd_wdata (a_wdata),
    .rcv_we    (b_acc & b_in0),
    .rcv_ofs   (b_addr),
    .rcv_wdata (b_wdata),
    .cmd_o     (cmd_ab),
    .dat_o     (dat_ab),
    .en_o      (en_ab),
    .pend_o    (pend_ab),
    .irq_o     (irq_to_b)
  );

  // B-to-A: B sends, A receives
  mbox_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_bank_ba (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .snd_we    (b_acc & b_in1),
    .snd_ofs   (b_ofs1),
    .snd_wdata (b_wdata),
    .rcv_we    (a_acc & a_in1),
    .rcv_ofs   (a_ofs1),
    .rcv_wdata (a_wdata),
    .cmd_o     (cmd_ba),
    .dat_o     (dat_ba),
    .en_o      (en_ba),
    .pend_o    (pend_ba),
    .irq_o     (irq_to_a)
  );

  mbox_rdmux #(.NCH(NCH), .DW(DW), .AW(AW)) u_rd_a (
    .addr  (a_addr),
    .cmd0  (cmd_ab), .dat0 (dat_ab), .en0 (en_ab), .pend0 (pend_ab),
    .cmd1  (cmd_ba), .dat1 (dat_ba), .en1 (en_ba), .pend1 (pend_ba),
    .rdata (a_rdata)
  );

  mbox_rdmux #(.NCH(NCH), .DW(DW), .AW(AW)) u_rd_b (
    .addr  (b_addr),
    .cmd0  (cmd_ab), .dat0 (dat_ab), .en0 (en_ab), .pend0 (pend_ab),
    .cmd1  (cmd_ba), .dat1 (dat_ba), .en1 (en_ba), .pend1 (pend_ba),
    .rdata (b_rdata)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |=> (irq_to_a == '0) && (irq_to_b == '0));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (a_addr >= END_A) |-> (a_rdata == '0));

endmodule

// File: tb/mbox_top_bench.sv
`timescale 1ns/1ps
module mbox_top_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_sel, a_enable, a_write;
  logic [7:0]  a_addr;
  logic [31:0] a_wdata, a_rdata;
  logic        b_sel, b_enable, b_write;
  logic [7:0]  b_addr;
  logic [31:0] b_wdata, b_rdata;
  logic [3:0]  irq_to_b, irq_to_a;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mbox_top u_mbox_top (
    .clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_enable(a_enable), .a_write(a_write),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_enable(b_enable), .b_write(b_write),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .irq_to_b(irq_to_b), .irq_to_a(irq_to_a)
  );

  typedef struct packed {
    logic        port;   // 0 = A, 1 = B
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 8'h08, 32'hDEAD0001, 32'h0,        8'd2},  // R2
    '{1'b0, 1'b0, 8'h08, 32'h0,        32'hDEAD0001, 8'd2},  // R2
    '{1'b1, 1'b0, 8'h08, 32'h0,        32'hDEAD0001, 8'd2},  // R2
    '{1'b0, 1'b0, 8'h04, 32'h0,        32'h0,        8'd11}, // R11
    '{1'b0, 1'b1, 8'h0C, 32'h11110000, 32'h0,        8'd3},  // R3
    '{1'b1, 1'b0, 8'h0C, 32'h0,        32'h11110000, 8'd2},  // R2
    '{1'b1, 1'b0, 8'h04, 32'h0,        32'h1,        8'd3},  // R3
    '{1'b0, 1'b1, 8'h24, 32'h00000033, 32'h0,        8'd3},  // R3
    '{1'b0, 1'b0, 8'h04, 32'h0,        32'h9,        8'd3},  // R3
    '{1'b1, 1'b1, 8'h04, 32'h00000001, 32'h0,        8'd4},  // R4
    '{1'b0, 1'b0, 8'h04, 32'h0,        32'h8,        8'd4},  // R4
    '{1'b1, 1'b1, 8'h30, 32'hCAFE0000, 32'h0,        8'd7},  // R7
    '{1'b1, 1'b1, 8'h3C, 32'h00000005, 32'h0,        8'd7},  // R7
    '{1'b0, 1'b0, 8'h2C, 32'h0,        32'h2,        8'd7},  // R7
    '{1'b0, 1'b0, 8'h3C, 32'h0,        32'h5,        8'd7},  // R7
    '{1'b0, 1'b1, 8'h00, 32'h0000000F, 32'h0,        8'd9},  // R9
    '{1'b1, 1'b0, 8'h00, 32'h0,        32'h0,        8'd9},  // R9
    '{1'b1, 1'b1, 8'h08, 32'h12345678, 32'h0,        8'd9},  // R9
    '{1'b0, 1'b0, 8'h08, 32'h0,        32'hDEAD0001, 8'd9},  // R9
    '{1'b0, 1'b1, 8'h50, 32'hFFFFFFFF, 32'h0,        8'd8},  // R8
    '{1'b0, 1'b0, 8'h50, 32'h0,        32'h0,        8'd8},  // R8
    '{1'b0, 1'b0, 8'h0A, 32'h0,        32'h0,        8'd8},  // R8
    '{1'b1, 1'b0, 8'hFC, 32'h0,        32'h0,        8'd8},  // R8
    '{1'b0, 1'b1, 8'h2C, 32'h00000000, 32'h0,        8'd4},  // R4
    '{1'b0, 1'b0, 8'h2C, 32'h0,        32'h2,        8'd4},  // R4
    '{1'b1, 1'b1, 8'h28, 32'h0000000F, 32'h0,        8'd9},  // R9
    '{1'b0, 1'b0, 8'h28, 32'h0,        32'h0,        8'd9}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_sel = 0; a_enable = 0; a_write = 0; a_addr = 0; a_wdata = 0;
    b_sel = 0; b_enable = 0; b_write = 0; b_addr = 0; b_wdata = 0;
  endtask

  // Two-phase write; returns at the falling edge after the capturing edge
  task automatic wr(input logic port, input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (port) begin b_sel = 1; b_write = 1; b_addr = ad; b_wdata = d; end
    else      begin a_sel = 1; a_write = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    if (port) b_enable = 1; else a_enable = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_both(input logic [7:0] aad, input logic [31:0] ad,
                         input logic [7:0] bad, input logic [31:0] bd);
    @(negedge clk);
    a_sel = 1; a_write = 1; a_addr = aad; a_wdata = ad;
    b_sel = 1; b_write = 1; b_addr = bad; b_wdata = bd;
    @(negedge clk);
    a_enable = 1; b_enable = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic port, input logic [7:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (port) begin b_sel = 1; b_addr = ad; end
    else      begin a_sel = 1; a_addr = ad; end
    #1;
    d = port ? b_rdata : a_rdata;
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] got;
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(1'b0, 8'h08, got); chk("R1 cmd0 after reset", got, 32'h0);
    rd(1'b1, 8'h04, got); chk("R1 A2B status after reset", got, 32'h0);
    chk("R1 irq_to_b after reset", {28'h0, irq_to_b}, 32'h0);
    chk("R1 irq_to_a after reset", {28'h0, irq_to_a}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].port, VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].port, VEC[i].addr, got);
        checks++;
        if (got !== VEC[i].exp) begin
          errors++;
          $display("FAIL R%0d vector %0d: actual %h expected %h",
                   VEC[i].req, i, got, VEC[i].exp);
        end
      end
    end

    // A2B pending = 0x8 now, enables off
    chk("R5 no irq while disabled", {28'h0, irq_to_b}, 32'h0);
    wr(1'b1, 8'h00, 32'hF);
    chk("R5 irq one cycle after enable", {28'h0, irq_to_b}, 32'h0);
    @(negedge clk);
    chk("R5 irq after enable", {28'h0, irq_to_b}, 32'h8);
    repeat (3) @(negedge clk);
    chk("R6 irq held", {28'h0, irq_to_b}, 32'h8);
    wr(1'b1, 8'h04, 32'h8);
    @(negedge clk);
    chk("R6 irq dropped by clear", {28'h0, irq_to_b}, 32'h0);

    // R10 same-cycle set and clear on channel 0
    wr_both(8'h0C, 32'h77, 8'h04, 32'h1);
    rd(1'b1, 8'h04, got); chk("R10 set wins status", got, 32'h1);
    chk("R10 irq follows", {28'h0, irq_to_b}, 32'h1);
    rd(1'b0, 8'h0C, got); chk("R2 data0 updated", got, 32'h77);
    wr(1'b1, 8'h04, 32'h0);
    rd(1'b1, 8'h04, got); chk("R4 zero write keeps pending", got, 32'h1);

    // R7 B2A interrupt (pending bit 1)
    wr(1'b0, 8'h28, 32'hF);
    @(negedge clk);
    chk("R7 irq_to_a after enable", {28'h0, irq_to_a}, 32'h2);
    wr(1'b0, 8'h28, 32'h0);
    @(negedge clk);
    chk("R5 irq_to_a dropped by disable", {28'h0, irq_to_a}, 32'h0);
    rd(1'b0, 8'h2C, got); chk("R6 pending kept after disable", got, 32'h2);

    // R1 reset mid-run
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 irq_to_b in reset", {28'h0, irq_to_b}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rd(1'b0, 8'h08, got); chk("R1 cmd cleared", got, 32'h0);
    rd(1'b0, 8'h3C, got); chk("R1 data cleared", got, 32'h0);
    rd(1'b1, 8'h00, got); chk("R1 enable cleared", got, 32'h0);
    rd(1'b0, 8'h2C, got); chk("R1 status cleared", got, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule